// File: doc/BRIEF.md
# Six-Channel Gain and Mute Stage

This block scales six signed 24-bit audio channels by a per-channel 8-bit linear gain code, where code 80h is unity and code 00h silences the channel. It sits between the serial-input deserialiser and the interpolation filter. One sample per channel arrives with a shared valid strobe. The scaled frame leaves two clock cycles later with its own valid strobe. Each product is rounded and saturated, so a large gain can never wrap a sample around.

There are two mute paths. A forced mute silences a pair of channels together. An automatic mute watches each channel for a run of zero samples. A per-channel counter advances on every sample-rate tick while the last sample of that channel was zero. When the counter reaches a parameterised tick count (4800 by default, about 0.1 s at 48 kHz), the channel's zero flag rises. While automatic mute is enabled and the flag is set, the next sample arriving on that channel is delivered as zero. That nonzero sample also clears the count and the flag.

Gain codes and pair-mute bits are taken only in the cycle of the input strobe. The internal held gain of every channel starts at 80h after reset.

Top module: `volMuteStage`

## Requirements
- R1: With gain code 80h and no mute, each output channel equals its input sample exactly.
- R2: Each output channel equals floor((sample × code + 64) / 128), computed as signed, for any code from 01h to FFh. Channel n (0-based) occupies bits [24n+23:24n] of the sample buses, and its gain code occupies bits [8n+7:8n] of the gain bus.
- R3: A scaled result above 7FFFFFh is output as 7FFFFFh, and a result below -800000h is output as 800000h.
- R4: Gain code 00h produces an output of zero for any sample.
- R5: Pair-mute bit p forces output channels 2p and 2p+1 (0-based) to zero for a sample presented while the bit is 1. Other channels are not affected.
- R6: The gain codes and pair-mute bits are sampled only in the cycle where inValid is 1. Changing them in any other cycle has no effect on a result already in flight.
- R7: Every cycle with inValid at 1 produces exactly one outValid pulse, two clock cycles later.
- R8: zeroFlag[n] rises once ZERO_TICKS rateTick pulses have been seen while channel n's most recent sample was zero. It does not rise one tick earlier. A nonzero sample on channel n clears the flag from the next cycle on.
- R9: When autoMuteOff is 0, a sample that arrives while zeroFlag[n] is 1 is output as zero on channel n. When autoMuteOff is 1, that sample is scaled normally. The flag itself does not depend on autoMuteOff.
- R10: During and after reset, before any input, outValid is 0, outSample is 0 and zeroFlag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | One frame of six samples is present |
| inSample | input | 144 | Six signed 24-bit samples, channel 0 in the low bits |
| gainCodes | input | 48 | Six 8-bit linear gain codes, 80h is unity |
| pairMute | input | 3 | Forced mute, one bit per channel pair |
| autoMuteOff | input | 1 | 1 disables the automatic mute |
| rateTick | input | 1 | One pulse per audio sample period |
| outValid | output | 1 | Scaled frame present on outSample |
| outSample | output | 144 | Six scaled, rounded, saturated samples |
| zeroFlag | output | 6 | Per-channel long-silence flag |

## Verification
A corrupted held gain or held mute bit appears as a wrong value on exactly one channel of the outValid frame, two cycles after the input strobe. This makes every scaling fault visible in the first frame after the fault. A counter that runs early or late moves the rising edge of zeroFlag by one tick, so the flag is checked both one tick before the limit and at the limit. A mute decision that uses the flag after it has already been cleared lets the first sample after a silence through. A frame with the flag set is therefore compared with zero when auto-mute is enabled and with the scaled value when it is disabled.

// File: rtl/volMutePkg.sv
package volMutePkg;
  localparam int NUM_CH      = 6;
  localparam int SAMPLE_W    = 24;
  localparam int GAIN_W      = 8;
  localparam int UNITY_SHIFT = 7;
  localparam int NUM_PAIR    = NUM_CH / 2;
  localparam int UNITY_CODE  = 1 << UNITY_SHIFT;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;  // load sample and gain into the stage
    logic              emit;     // stage holds a frame, write the outputs
    logic [NUM_CH-1:0] muteHeld; // per-channel mute for the staged frame
  } ctrlStrobeT;
endpackage

// File: rtl/volMuteCtrl.sv
module volMuteCtrl
  import volMutePkg::*;
#(
  parameter int ZERO_TICKS = 4800
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [NUM_CH-1:0]   inZero,
  input  logic [NUM_PAIR-1:0] pairMute,
  input  logic                autoMuteOff,
  input  logic                rateTick,
  output ctrlStrobeT          strobes,
  output logic [NUM_CH-1:0]   zeroFlag
);
  localparam int CNT_W = $clog2(ZERO_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(ZERO_TICKS);

  logic              stageValid;
  logic [NUM_CH-1:0] muteReg;
  logic [NUM_CH-1:0] lastZero;
  logic [NUM_CH-1:0] flagNow;
  logic [CNT_W-1:0]  zeroCnt [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      muteReg    <= '0;
    end else begin
      stageValid <= inValid;
      if (inValid) begin
        for (int c = 0; c < NUM_CH; c++) begin
          muteReg[c] <= pairMute[c/2] | (~autoMuteOff & flagNow[c]);
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gSilence
    assign flagNow[c] = (zeroCnt[c] == CNT_LIMIT);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        zeroCnt[c]  <= '0;
        lastZero[c] <= 1'b1;
      end else begin
        if (inValid) lastZero[c] <= inZero[c];
        if (inValid && !inZero[c]) begin
          zeroCnt[c] <= '0;
        end else if (rateTick && lastZero[c] && !flagNow[c]) begin
          zeroCnt[c] <= zeroCnt[c] + CNT_W'(1);
        end
      end
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
      zeroCnt[c] <= CNT_LIMIT);

    assert_flag_release_R8: assert property (@(posedge clk) disable iff (!rstN)
      $fell(zeroFlag[c]) |-> $past(inValid && !inZero[c]));
  end

  assign strobes.capture  = inValid;
  assign strobes.emit     = stageValid;
  assign strobes.muteHeld = muteReg;
  assign zeroFlag         = flagNow;
endmodule

// File: rtl/volMuteDatapath.sv
module volMuteDatapath
  import volMutePkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0] inSample,
  input  logic [NUM_CH*GAIN_W-1:0]   gainCodes,
  input  ctrlStrobeT                 strobes,
  output logic [NUM_CH-1:0]          inZero,
  output logic                       outValid,
  output logic [NUM_CH*SAMPLE_W-1:0] outSample
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 2;
  localparam logic signed [PROD_W-1:0] ROUND_ADD = PROD_W'(1) <<< (UNITY_SHIFT - 1);
  localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam logic signed [PROD_W-1:0] MIN_V = -MAX_V - PROD_W'(1);
  localparam logic [GAIN_W-1:0] UNITY_G = GAIN_W'(UNITY_CODE);

  logic signed [SAMPLE_W-1:0] stSample [NUM_CH];
  logic        [GAIN_W-1:0]   stGain   [NUM_CH];
  logic        [SAMPLE_W-1:0] satVal   [NUM_CH];
  logic        [SAMPLE_W-1:0] outArr   [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        stSample[c] <= '0;
        stGain[c]   <= UNITY_G;
      end
    end else if (strobes.capture) begin
      for (int c = 0; c < NUM_CH; c++) begin
        stSample[c] <= inSample[c*SAMPLE_W +: SAMPLE_W];
        stGain[c]   <= gainCodes[c*GAIN_W +: GAIN_W];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gLane
    logic signed [PROD_W-1:0] sExt, gExt, prod, scaled;

    assign inZero[c] = (inSample[c*SAMPLE_W +: SAMPLE_W] == '0);

    always_comb begin
      sExt   = PROD_W'(stSample[c]);
      gExt   = $signed(PROD_W'(stGain[c]));
      prod   = sExt * gExt;
      scaled = (prod + ROUND_ADD) >>> UNITY_SHIFT;
      if (scaled > MAX_V)      satVal[c] = MAX_V[SAMPLE_W-1:0];
      else if (scaled < MIN_V) satVal[c] = MIN_V[SAMPLE_W-1:0];
      else                     satVal[c] = scaled[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)             outArr[c] <= '0;
      else if (strobes.emit) outArr[c] <= strobes.muteHeld[c] ? '0 : satVal[c];
    end

    assign outSample[c*SAMPLE_W +: SAMPLE_W] = outArr[c];

    assert_unity_R1: assert property (@(posedge clk) disable iff (!rstN)
      strobes.emit && stGain[c] == UNITY_G && !strobes.muteHeld[c]
      |=> outArr[c] == $past(stSample[c]));

    assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobes.emit && stGain[c] == '0 |=> outArr[c] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobes.emit;
  end
endmodule

// File: rtl/volMuteStage.sv
module volMuteStage
  import volMutePkg::*;
#(
  parameter int ZERO_TICKS = 4800
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] inSample,
  input  logic [NUM_CH*GAIN_W-1:0]   gainCodes,
  input  logic [NUM_PAIR-1:0]        pairMute,
  input  logic                       autoMuteOff,
  input  logic                       rateTick,
  output logic                       outValid,
  output logic [NUM_CH*SAMPLE_W-1:0] outSample,
  output logic [NUM_CH-1:0]          zeroFlag
);
  ctrlStrobeT        strobes;
  logic [NUM_CH-1:0] inZero;

  volMuteCtrl #(.ZERO_TICKS(ZERO_TICKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inZero(inZero),
    .pairMute(pairMute), .autoMuteOff(autoMuteOff), .rateTick(rateTick),
    .strobes(strobes), .zeroFlag(zeroFlag)
  );

  volMuteDatapath i_data (
    .clk(clk), .rstN(rstN), .inSample(inSample), .gainCodes(gainCodes),
    .strobes(strobes), .inZero(inZero), .outValid(outValid), .outSample(outSample)
  );

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  for (genvar c = 0; c < NUM_CH; c++) begin : gChk
    assert_pair_mute_R5: assert property (@(posedge clk) disable iff (!rstN)
      $past(inValid, 2) && $past(pairMute[c/2], 2)
      |-> outSample[c*SAMPLE_W +: SAMPLE_W] == '0);

    assert_auto_mute_R9: assert property (@(posedge clk) disable iff (!rstN)
      $past(inValid, 2) && $past(zeroFlag[c] && !autoMuteOff, 2)
      |-> outSample[c*SAMPLE_W +: SAMPLE_W] == '0);
  end
endmodule

// File: tb/test_volMuteStage.sv
module test_volMuteStage;
  import volMutePkg::*;
  localparam int TICKS = 8;
  localparam int SW = SAMPLE_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, inValid, autoMuteOff, rateTick, outValid;
  logic [NUM_CH*SW-1:0]     inSample, outSample;
  logic [NUM_CH*GAIN_W-1:0] gainCodes;
  logic [NUM_PAIR-1:0]      pairMute;
  logic [NUM_CH-1:0]        zeroFlag;

  volMuteStage #(.ZERO_TICKS(TICKS)) i_volMuteStage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .gainCodes(gainCodes), .pairMute(pairMute), .autoMuteOff(autoMuteOff),
    .rateTick(rateTick), .outValid(outValid), .outSample(outSample),
    .zeroFlag(zeroFlag)
  );

  int checks = 0, errors = 0;
  longint cyc = 0;
  logic [NUM_CH*SW-1:0] expQ[$];
  string tagQ[$];
  longint dueQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [SW-1:0] model(longint s, longint g);
    longint p;
    p = (s * g + 64) >>> 7;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return SW'(p);
  endfunction

  task automatic check(bit ok, string tag, string what, longint got, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic sendSample(input longint s[NUM_CH], input longint g[NUM_CH],
                            input logic [NUM_PAIR-1:0] pm,
                            input logic [NUM_CH-1:0] autoMuted, input string tag);
    logic [NUM_CH*SW-1:0] e;
    @(negedge clk);
    for (int c = 0; c < NUM_CH; c++) begin
      inSample[c*SW +: SW]          = SW'(s[c]);
      gainCodes[c*GAIN_W +: GAIN_W] = GAIN_W'(g[c]);
      e[c*SW +: SW] = (pm[c/2] || autoMuted[c]) ? '0 : model(s[c], g[c]);
    end
    pairMute = pm;
    inValid  = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    dueQ.push_back(cyc + 2);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk) rateTick = 1'b1;
    @(negedge clk) rateTick = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected outValid", 1, 0);
      end else begin
        automatic logic [NUM_CH*SW-1:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        automatic longint d = dueQ.pop_front();
        check(d == cyc, "R7", "arrival cycle", cyc, d);
        for (int c = 0; c < NUM_CH; c++) begin
          check(outSample[c*SW +: SW] == e[c*SW +: SW], t, $sformatf("channel %0d", c),
                longint'($signed(outSample[c*SW +: SW])), longint'($signed(e[c*SW +: SW])));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; autoMuteOff = 1'b0; rateTick = 1'b0;
    inSample = '0; gainCodes = {NUM_CH{8'h80}}; pairMute = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R10", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R10", "outValid after reset", outValid, 0);
    check(outSample == '0, "R10", "outSample after reset", longint'(outSample[SW-1:0]), 0);
    check(zeroFlag == '0, "R10", "zeroFlag after reset", zeroFlag, 0);

    // R1 unity gain
    sendSample('{100, -100, 8388607, -8388608, 'h123456, -1},
               '{128, 128, 128, 128, 128, 128}, 3'b000, 6'b0, "R1");
    // R2 mixed codes
    sendSample('{100, -100, 5000, -77777, 8388607, -3},
               '{'h40, 'h40, 'h01, 'hC0, 'h7F, 'h02}, 3'b000, 6'b0, "R2");
    sendSample('{-1, 1, 63, -65, 12345, -8388608},
               '{'h01, 'hFF, 'h01, 'h01, 'hA5, 'h81}, 3'b000, 6'b0, "R2");
    // R3 saturation
    sendSample('{8388607, -8388608, 4194304, -4194305, 7000000, -7000000},
               '{'hFF, 'hFF, 'h100 - 'h1, 'h81, 'hC8, 'hC8}, 3'b000, 6'b0, "R3");
    // R4 zero code
    sendSample('{8388607, -8388608, 5, -5, 1, 99},
               '{0, 0, 0, 0, 0, 0}, 3'b000, 6'b0, "R4");
    // R5 pair mute on middle pair
    sendSample('{11, 22, 33, 44, 55, 66},
               '{128, 128, 128, 128, 128, 128}, 3'b010, 6'b0, "R5");
    sendSample('{-11, -22, -33, -44, -55, -66},
               '{128, 128, 128, 128, 128, 128}, 3'b101, 6'b0, "R5");
    // R6 change gain and mute after the strobe
    sendSample('{1000, 2000, 3000, 4000, 5000, 6000},
               '{'h40, 'h40, 'h40, 'h40, 'h40, 'h40}, 3'b000, 6'b0, "R6");
    gainCodes = {NUM_CH{8'hFF}};
    pairMute  = 3'b111;
    inSample  = '0;
    @(negedge clk);
    gainCodes = '0;
    repeat (2) @(negedge clk);
    check(zeroFlag == '0, "R6", "zeroFlag untouched", zeroFlag, 0);

    // R8 zero detection on channel 0
    sendSample('{0, 7, 8, 9, 10, 11},
               '{128, 128, 128, 128, 128, 128}, 3'b000, 6'b0, "R8");
    repeat (2) @(negedge clk);
    for (int i = 0; i < TICKS - 1; i++) tick();
    check(zeroFlag == 6'b000000, "R8", "flag one tick early", zeroFlag, 0);
    tick();
    check(zeroFlag == 6'b000001, "R8", "flag at limit", zeroFlag, 1);
    tick();
    check(zeroFlag == 6'b000001, "R8", "flag holds", zeroFlag, 1);
    // R9 auto-mute enabled suppresses first nonzero sample
    sendSample('{1000, 7, 8, 9, 10, 11},
               '{128, 128, 128, 128, 128, 128}, 3'b000, 6'b000001, "R9");
    check(zeroFlag == 6'b000000, "R8", "flag cleared by nonzero", zeroFlag, 0);

    // R9 auto-mute disabled passes the sample on channel 1
    autoMuteOff = 1'b1;
    sendSample('{5, 0, 8, 9, 10, 11},
               '{128, 128, 128, 128, 128, 128}, 3'b000, 6'b0, "R8");
    repeat (2) @(negedge clk);
    for (int i = 0; i < TICKS; i++) tick();
    check(zeroFlag == 6'b000010, "R9", "flag independent of enable", zeroFlag, 2);
    sendSample('{5, -2000, 8, 9, 10, 11},
               '{128, 'h40, 128, 128, 128, 128}, 3'b000, 6'b0, "R9");
    check(zeroFlag == 6'b000000, "R8", "flag cleared", zeroFlag, 0);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R7", "frames outstanding", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule